// File: doc/BRIEF.md
# Line-Cycle Energy Accumulator

This block sums signed per-phase power samples into a 32-bit signed energy result. It runs in one of two modes, chosen by a single enable. With the enable low, every valid sample is added straight into the result register. That register wraps on overflow, sets a sticky flag, and can be cleared by a read request.

With the enable high, a separate window accumulator gathers the samples. A countdown, loaded with a programmed number of half line cycles, is decremented by the zero-crossing pulses of whichever of the three phases are selected. When the countdown is used up, the window sum moves into the result register in one step and a completion flag is raised. The window then restarts at once, so no sample falls between two windows.

Power computation and zero-crossing detection take place upstream. This block only receives their strobes.

Top module: `lcyc_energy_acc`

## Requirements
- R1: With `lc_en` low, each cycle with `smp_vld` high adds the sign-extended 24-bit `smp_pwr` into the 32-bit two's-complement `energy_out`, which is visible one cycle later and wraps modulo 2^32; cycles without `smp_vld` leave it unchanged.
- R2: With `lc_en` low, a cycle with `rd_req` and `rd_clr` both high loads `energy_out` with that cycle's sample if `smp_vld` is high, else with 0; `rd_req` alone does not clear.
- R3: With `lc_en` low, an addition whose signed result leaves the range -2^31..0x7FFFFFFF sets `ovf_flag`, which then stays high until reset.
- R4: In the first cycle with `lc_en` high after it was low, the window restarts from that cycle's sample (0 if none), the countdown loads `half_cycles`, and crossings in that cycle are not counted; in line-cycle mode `energy_out` changes only at a transfer.
- R5: Only crossings of phases whose `phase_sel` bit is 1 count (bit 0 phase A, bit 1 phase B, bit 2 phase C); selected crossings in the same cycle each decrement the countdown by one.
- R6: When the counted crossings in a cycle reach the remaining count, `energy_out` receives the sum of the window's samples before that cycle, the window restarts from that cycle's sample (0 if none), and the countdown reloads `half_cycles`.
- R7: The countdown never goes below zero; surplus crossings in the transfer cycle are dropped.
- R8: With `half_cycles` equal to 0 when line-cycle mode starts, no transfer ever occurs and the done flag is never raised.
- R9: A transfer sets an internal done flag, which `rd_req` clears (a transfer in the same cycle wins); `done_irq` is the done flag ANDed with `irq_en`.
- R10: With `lc_en` high, `rd_req` with `rd_clr` leaves `energy_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_vld | input | 1 | Power sample valid strobe |
| smp_pwr | input | 24 | Signed power sample |
| zc_pulse | input | 3 | Zero-crossing pulses, bit 0 phase A .. bit 2 phase C |
| lc_en | input | 1 | Line-cycle mode enable |
| phase_sel | input | 3 | Phases whose crossings are counted |
| half_cycles | input | 16 | Half line cycles per window |
| rd_req | input | 1 | Result read strobe |
| rd_clr | input | 1 | Clear the result on read (free-running mode only) |
| irq_en | input | 1 | Done interrupt mask |
| energy_out | output | 32 | Signed energy result |
| done_irq | output | 1 | Masked done interrupt |
| ovf_flag | output | 1 | Sticky free-running overflow flag |

## Verification
On every cycle, the assertions check these properties:
- the countdown never increases except at a load or a transfer, and never underflows;
- the result holds still in line-cycle mode outside transfers, including when a read asks for a clear;
- a transfer always leaves the done flag set;
- free-running sums follow the previous result plus the sample;
- the overflow flag is sticky;
- a zero count never lets a transfer through.

Only the bench scenarios show the following:
- the exact window sums that land at a transfer, including the sample in the transfer cycle being carried into the next window;
- how masked and simultaneous crossings are counted;
- the wrap value at overflow;
- the interplay between interrupt masking and read acknowledgement.

// File: rtl/lca_pkg.sv
package lca_pkg;

  typedef enum logic {
    LCA_FREE = 1'b0,
    LCA_LINE = 1'b1
  } lca_mode_e;

  // Population count of up to eight strobes.
  function automatic logic [3:0] lca_pop8(input logic [7:0] v);
    logic [3:0] n;
    n = '0;
    for (int i = 0; i < 8; i++) n = n + {3'b000, v[i]};
    return n;
  endfunction

endpackage

// File: rtl/lca_zc_counter.sv
module lca_zc_counter #(
  parameter int unsigned NPH = 3,
  parameter int unsigned CW  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           lc_en,
  input  logic           lc_start,
  input  logic [NPH-1:0] zc_pulse,
  input  logic [NPH-1:0] phase_sel,
  input  logic [CW-1:0]  half_cycles,
  output logic           xfer,
  output logic [CW-1:0]  rem_cnt
);
  import lca_pkg::*;

  localparam int unsigned HW = $clog2(NPH + 1);

  logic [NPH-1:0] hit_vec;
  logic [7:0]     hit_pad;
  logic [3:0]     hit_pop;
  logic [HW-1:0]  hits;
  logic [CW-1:0]  hits_ext;
  logic [CW-1:0]  rem_q;

  // One gated strobe per phase.
  genvar g;
  generate
    for (g = 0; g < NPH; g++) begin : g_phase
      assign hit_vec[g] = zc_pulse[g] & phase_sel[g];
    end
  endgenerate

  always_comb begin
    hit_pad = '0;
    hit_pad[NPH-1:0] = hit_vec;
  end

  assign hit_pop  = lca_pop8(hit_pad);
  assign hits     = hit_pop[HW-1:0];
  assign hits_ext = CW'(hits);

  // Saturating countdown step.
  function automatic logic [CW-1:0] sat_dec(input logic [CW-1:0] r, input logic [CW-1:0] h);
    return (h >= r) ? '0 : r - h;
  endfunction

  assign xfer = lc_en && !lc_start && (rem_q != '0) && (hits_ext >= rem_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rem_q <= '0;
    else if (lc_start)   rem_q <= half_cycles;
    else if (!lc_en)     rem_q <= rem_q;
    else if (xfer)       rem_q <= half_cycles;
    else                 rem_q <= sat_dec(rem_q, hits_ext);
  end

  assign rem_cnt = rem_q;

endmodule

// File: rtl/lca_window_acc.sv
module lca_window_acc #(
  parameter int unsigned EW = 32,
  parameter int unsigned PW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lc_en,
  input  logic          restart,
  input  logic          smp_vld,
  input  logic [PW-1:0] smp_pwr,
  output logic [EW-1:0] win_sum
);
  localparam int unsigned XW = EW - PW;

  function automatic logic [EW-1:0] sext(input logic [PW-1:0] s);
    return {{XW{s[PW-1]}}, s};
  endfunction

  logic [EW-1:0] acc_q;
  logic [EW-1:0] seed;

  assign seed = smp_vld ? sext(smp_pwr) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 acc_q <= '0;
    else if (restart)           acc_q <= seed;
    else if (lc_en && smp_vld)  acc_q <= acc_q + seed;
  end

  assign win_sum = acc_q;

endmodule

// File: rtl/lca_result_reg.sv
module lca_result_reg #(
  parameter int unsigned EW = 32,
  parameter int unsigned PW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lc_en,
  input  logic          xfer,
  input  logic [EW-1:0] win_sum,
  input  logic          smp_vld,
  input  logic [PW-1:0] smp_pwr,
  input  logic          rd_req,
  input  logic          rd_clr,
  output logic [EW-1:0] energy,
  output logic          ovf,
  output logic          add_ovf
);
  localparam int unsigned XW = EW - PW;

  function automatic logic [EW-1:0] sext(input logic [PW-1:0] s);
    return {{XW{s[PW-1]}}, s};
  endfunction

  // Signed overflow: operands agree in sign, result does not.
  function automatic logic sum_ovf(input logic [EW-1:0] a, input logic [EW-1:0] b,
                                   input logic [EW-1:0] s);
    return (a[EW-1] == b[EW-1]) && (s[EW-1] != a[EW-1]);
  endfunction

  logic [EW-1:0] addend;
  logic [EW-1:0] sum;
  logic [EW-1:0] energy_q;
  logic          ovf_q;
  logic          clr_hit;

  assign addend  = sext(smp_pwr);
  assign sum     = energy_q + addend;
  assign clr_hit = rd_req && rd_clr;
  assign add_ovf = !lc_en && smp_vld && !clr_hit && sum_ovf(energy_q, addend, sum);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      energy_q <= '0;
      ovf_q    <= 1'b0;
    end else begin
      if (xfer)                 energy_q <= win_sum;
      else if (!lc_en) begin
        if (clr_hit)            energy_q <= smp_vld ? addend : '0;
        else if (smp_vld)       energy_q <= sum;
      end
      if (add_ovf)              ovf_q <= 1'b1;
    end
  end

  assign energy = energy_q;
  assign ovf    = ovf_q;

endmodule

// File: rtl/lcyc_energy_acc.sv
module lcyc_energy_acc #(
  parameter int unsigned EW  = 32,
  parameter int unsigned PW  = 24,
  parameter int unsigned NPH = 3,
  parameter int unsigned CW  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           smp_vld,
  input  logic [PW-1:0]  smp_pwr,
  input  logic [NPH-1:0] zc_pulse,
  input  logic           lc_en,
  input  logic [NPH-1:0] phase_sel,
  input  logic [CW-1:0]  half_cycles,
  input  logic           rd_req,
  input  logic           rd_clr,
  input  logic           irq_en,
  output logic [EW-1:0]  energy_out,
  output logic           done_irq,
  output logic           ovf_flag
);
  import lca_pkg::*;

  lca_mode_e     mode_q;
  logic          lc_start;
  logic          xfer;
  logic [CW-1:0] rem_cnt;
  logic [EW-1:0] win_sum;
  logic          done_q;
  logic          add_ovf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= LCA_FREE;
    else        mode_q <= lc_en ? LCA_LINE : LCA_FREE;
  end

  assign lc_start = lc_en && (mode_q == LCA_FREE);

  lca_zc_counter #(.NPH(NPH), .CW(CW)) u_zc (
    .clk(clk), .rst_n(rst_n), .lc_en(lc_en), .lc_start(lc_start),
    .zc_pulse(zc_pulse), .phase_sel(phase_sel), .half_cycles(half_cycles),
    .xfer(xfer), .rem_cnt(rem_cnt)
  );

  lca_window_acc #(.EW(EW), .PW(PW)) u_win (
    .clk(clk), .rst_n(rst_n), .lc_en(lc_en), .restart(lc_start || xfer),
    .smp_vld(smp_vld), .smp_pwr(smp_pwr), .win_sum(win_sum)
  );

  lca_result_reg #(.EW(EW), .PW(PW)) u_res (
    .clk(clk), .rst_n(rst_n), .lc_en(lc_en), .xfer(xfer), .win_sum(win_sum),
    .smp_vld(smp_vld), .smp_pwr(smp_pwr), .rd_req(rd_req), .rd_clr(rd_clr),
    .energy(energy_out), .ovf(ovf_flag), .add_ovf(add_ovf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      done_q <= 1'b0;
    else if (xfer)   done_q <= 1'b1;
    else if (rd_req) done_q <= 1'b0;
  end

  assign done_irq = done_q && irq_en;

endmodule

// File: rtl/lcyc_energy_acc_chk.sv
module lcyc_energy_acc_chk #(
  parameter int unsigned EW  = 32,
  parameter int unsigned PW  = 24,
  parameter int unsigned CW  = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lc_en,
  input logic          lc_start,
  input logic          xfer,
  input logic [CW-1:0] rem_cnt,
  input logic [CW-1:0] half_cycles,
  input logic          smp_vld,
  input logic [PW-1:0] smp_pwr,
  input logic          rd_req,
  input logic          rd_clr,
  input logic [EW-1:0] energy_out,
  input logic          ovf_flag,
  input logic          done_q
);
  logic [EW-1:0] smp_ext;
  assign smp_ext = {{(EW-PW){smp_pwr[PW-1]}}, smp_pwr};

  // R1: free-running sum follows previous result plus sample
  p_free_add_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!lc_en && smp_vld && !(rd_req && rd_clr)) |=> energy_out == $past(energy_out) + $past(smp_ext));

  // R3: overflow flag is sticky
  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |=> ovf_flag);

  // R4, R10: result frozen in line-cycle mode outside transfers
  p_hold_line_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (lc_en && !xfer) |=> $stable(energy_out));

  // R4: entry loads the programmed count
  p_load_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lc_start |=> rem_cnt == $past(half_cycles));

  // R7: countdown never rises except at load or transfer
  p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lc_en && !lc_start && !xfer) |=> rem_cnt <= $past(rem_cnt));

  // R8: a zero countdown never transfers
  p_zero_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rem_cnt == '0 && !lc_start) |-> !xfer);

  // R9: transfer raises the done flag
  p_done_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> done_q);

endmodule

bind lcyc_energy_acc lcyc_energy_acc_chk #(.EW(EW), .PW(PW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .lc_en(lc_en), .lc_start(lc_start), .xfer(xfer),
  .rem_cnt(rem_cnt), .half_cycles(half_cycles), .smp_vld(smp_vld), .smp_pwr(smp_pwr),
  .rd_req(rd_req), .rd_clr(rd_clr), .energy_out(energy_out), .ovf_flag(ovf_flag),
  .done_q(done_q)
);

// File: tb/test_lcyc_energy_acc.sv
module test_lcyc_energy_acc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_vld = 1'b0;
  logic [23:0] smp_pwr = '0;
  logic [2:0]  zc_pulse = '0;
  logic        lc_en = 1'b0;
  logic [2:0]  phase_sel = '0;
  logic [15:0] half_cycles = '0;
  logic        rd_req = 1'b0;
  logic        rd_clr = 1'b0;
  logic        irq_en = 1'b1;
  logic [31:0] energy_out;
  logic        done_irq;
  logic        ovf_flag;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  lcyc_energy_acc i_lcyc_energy_acc (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_pwr(smp_pwr), .zc_pulse(zc_pulse),
    .lc_en(lc_en), .phase_sel(phase_sel), .half_cycles(half_cycles), .rd_req(rd_req),
    .rd_clr(rd_clr), .irq_en(irq_en), .energy_out(energy_out), .done_irq(done_irq),
    .ovf_flag(ovf_flag)
  );

  // Free-running vectors: valid, sample, expected running sum.
  localparam int NV = 8;
  localparam logic        V_VLD [NV] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1};
  localparam logic [23:0] V_SMP [NV] = '{24'd100, -24'sd50, 24'd999, -24'sd200,
                                         24'h7FFFFF, 24'h800000, 24'd151, -24'sd1};
  localparam logic [31:0] V_EXP [NV] = '{32'd100, 32'd50, 32'd50, -32'sd150,
                                         32'd8388457, -32'sd151, 32'd0, 32'hFFFFFFFF};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive at a negedge, let one rising edge pass, return at the next negedge.
  task automatic tick(input logic v, input logic [23:0] s, input logic [2:0] z,
                      input logic rq, input logic rc);
    smp_vld = v; smp_pwr = s; zc_pulse = z; rd_req = rq; rd_clr = rc;
    @(posedge clk);
    @(negedge clk);
    smp_vld = 0; zc_pulse = '0; rd_req = 0; rd_clr = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("reset energy", energy_out, 32'd0);
    chk("reset done R9", {31'd0, done_irq}, 32'd0);
    chk("reset ovf R3", {31'd0, ovf_flag}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: table walk
    for (int i = 0; i < NV; i++) begin
      tick(V_VLD[i], V_SMP[i], 3'b000, 1'b0, 1'b0);
      chk($sformatf("R1 vector %0d", i), energy_out, V_EXP[i]);
    end

    // R2: read with clear
    tick(1'b0, 24'd0, 3'b000, 1'b1, 1'b1);
    chk("R2 clear", energy_out, 32'd0);
    tick(1'b1, 24'd77, 3'b000, 1'b1, 1'b1);
    chk("R2 clear keeps sample", energy_out, 32'd77);
    tick(1'b1, 24'd3, 3'b000, 1'b1, 1'b0);
    chk("R2 read without clear", energy_out, 32'd80);

    // R3: overflow
    tick(1'b0, 24'd0, 3'b000, 1'b1, 1'b1);
    for (int i = 0; i < 256; i++) tick(1'b1, 24'h7FFFFF, 3'b000, 1'b0, 1'b0);
    chk("R3 at limit", energy_out, 32'h7FFFFF00);
    chk("R3 no ovf yet", {31'd0, ovf_flag}, 32'd0);
    tick(1'b1, 24'h7FFFFF, 3'b000, 1'b0, 1'b0);
    chk("R3 wrap", energy_out, 32'h807FFEFF);
    chk("R3 ovf set", {31'd0, ovf_flag}, 32'd1);
    tick(1'b1, 24'hFFFFFF, 3'b000, 1'b0, 1'b0);
    chk("R3 ovf sticky", {31'd0, ovf_flag}, 32'd1);
    tick(1'b0, 24'd0, 3'b000, 1'b1, 1'b1);
    chk("R2 clear before window", energy_out, 32'd0);

    // R4-R6: line-cycle window, count 3, phases A and C
    half_cycles = 16'd3; phase_sel = 3'b101; irq_en = 1'b1;
    lc_en = 1'b1;
    tick(1'b1, 24'd10, 3'b111, 1'b0, 1'b0);  // entry, crossings ignored
    chk("R4 result held at entry", energy_out, 32'd0);
    tick(1'b1, 24'd10, 3'b010, 1'b0, 1'b0);  // phase B masked
    chk("R5 masked phase", {31'd0, done_irq}, 32'd0);
    chk("R4 result held", energy_out, 32'd0);
    tick(1'b1, 24'd10, 3'b101, 1'b0, 1'b0);  // two counted
    chk("R5 two crossings no transfer", {31'd0, done_irq}, 32'd0);
    tick(1'b1, 24'd5, 3'b001, 1'b0, 1'b0);   // reaches zero
    chk("R6 window sum", energy_out, 32'd30);
    chk("R9 done raised", {31'd0, done_irq}, 32'd1);

    // R10 and R9 acknowledge
    tick(1'b0, 24'd0, 3'b000, 1'b1, 1'b1);
    chk("R10 no clear in line mode", energy_out, 32'd30);
    chk("R9 read clears done", {31'd0, done_irq}, 32'd0);

    // R6 carry of transfer-cycle sample, R7 saturation
    tick(1'b1, 24'd1, 3'b001, 1'b0, 1'b0);   // rem 2, acc 6
    tick(1'b0, 24'd0, 3'b101, 1'b0, 1'b0);   // transfer of 6
    chk("R6 carried sample", energy_out, 32'd6);
    tick(1'b1, 24'd4, 3'b111, 1'b0, 1'b0);   // rem 1, acc 4
    chk("R5 simultaneous crossings", energy_out, 32'd6);
    tick(1'b0, 24'd0, 3'b101, 1'b0, 1'b0);   // surplus crossing
    chk("R7 transfer with surplus", energy_out, 32'd4);
    tick(1'b0, 24'd0, 3'b001, 1'b0, 1'b0);
    tick(1'b0, 24'd0, 3'b001, 1'b0, 1'b0);
    chk("R7 reloaded full count", energy_out, 32'd4);
    tick(1'b1, 24'd9, 3'b001, 1'b0, 1'b0);
    chk("R7 next window", energy_out, 32'd0);

    // R9 mask
    irq_en = 1'b0; #1;
    chk("R9 masked irq", {31'd0, done_irq}, 32'd0);
    irq_en = 1'b1; #1;
    chk("R9 unmasked irq", {31'd0, done_irq}, 32'd1);

    // R8: zero count
    lc_en = 1'b0;
    tick(1'b0, 24'd0, 3'b000, 1'b1, 1'b0);
    half_cycles = 16'd0; lc_en = 1'b1;
    tick(1'b1, 24'd2, 3'b000, 1'b0, 1'b0);
    for (int i = 0; i < 5; i++) tick(1'b1, 24'd2, 3'b111, 1'b0, 1'b0);
    chk("R8 no done", {31'd0, done_irq}, 32'd0);
    chk("R8 result unchanged", energy_out, 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule